// File: doc/BRIEF.md
# Display Controller Self-Test Sequencer

This block runs the built-in self-test of a dot-matrix character display controller. A host write to the control word with bit 6 set starts a run of fixed length. During the first part of the run the sequencer walks the external font lookup through every character code and every dot row. It adds each returned row value into an 8-bit checksum. During the rest of the run it overrides the display with a checkerboard, then with the inverted checkerboard, for equal halves of the remaining time.

While the run is in progress the sequencer raises `busy`, which the surrounding controller uses to refuse host access. When the run ends, it does three things on the same edge:
- It pulses `done` for one clock. The surrounding controller uses this pulse to fill character memory with the space code 20h, clear the flash attributes, load all ones into the custom-glyph address register and zero the control word.
- It updates `pass_bit`, which the controller presents as control word bit 5.
- It drops `busy`.

Bit 5 cannot be written by the host. The value of `pass_bit` changes only at the end of a run.

Top module: `selftest_seq`

## Requirements
- R1: After reset, `busy`, `done`, `pass_bit`, `pat_en` and `pat_inv` are all 0.
- R2: A cycle with `cw_wr`=1, `cw_wdata[6]`=1 and `busy`=0 starts a run: `busy` is 1 from the following cycle for exactly TOTAL_CYCLES cycles. A write with bit 6 clear starts nothing.
- R3: Writes presented while `busy`=1 have no effect. The run is neither restarted nor extended, and `pass_bit` is unchanged.
- R4: In run cycle k (k = 0 for the first busy cycle), for k < NUM_CODES*NUM_ROWS, `font_code` = k / NUM_ROWS and `font_row` = k mod NUM_ROWS. `font_row` never exceeds NUM_ROWS-1.
- R5: The checksum is the sum modulo 256 of every `font_data` value (zero-extended) seen during those walk cycles. `pass_bit` becomes 1 at the end of the run if the checksum equals EXPECTED_SUM, and 0 otherwise.
- R6: In run cycles from NUM_CODES*NUM_ROWS up to the midpoint of the remaining cycles, `pat_en`=1 and `pat_inv`=0. For the remaining run cycles, `pat_en`=1 and `pat_inv`=1. Outside those cycles `pat_en`=0.
- R7: `done` is 1 for exactly one cycle, the first cycle after the last busy cycle, and `busy` is 0 in that cycle.
- R8: `pass_bit` is read-only to the host and changes only in the cycle in which `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cw_wr | input | 1 | Control word write strobe |
| cw_wdata | input | 8 | Control word write data; bit 6 requests the test |
| font_code | output | 7 | Character code presented to the font lookup |
| font_row | output | 3 | Dot row presented to the font lookup |
| font_data | input | 5 | Row dots returned by the font lookup (same cycle) |
| busy | output | 1 | Test running; host access blocked |
| pat_en | output | 1 | Display pattern override active |
| pat_inv | output | 1 | 0 = checkerboard, 1 = inverted checkerboard |
| done | output | 1 | One-cycle end pulse; triggers state restore |
| pass_bit | output | 1 | Test result, shown as control word bit 5 |

## Verification
The failing checksum is the hardest case to reach from the ports, because a correct font never yields a mismatch. The bench uses a font model that it can corrupt: at one randomly chosen code it flips a row bit, for one run. This gives a run that must fail, and a following clean run must bring `pass_bit` back to 1. Random writes during a run are timed to arrive at random points, including points inside the walk phase and the pattern phase, to show that the run is neither restarted nor stretched.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  typedef enum logic [1:0] {
    PH_WALK  = 2'd0,
    PH_CHECK = 2'd1,
    PH_INV   = 2'd2,
    PH_IDLE  = 2'd3
  } st_phase_e;

  localparam int unsigned CW_START_BIT = 6;
endpackage

// File: rtl/selftest_timer.sv
module selftest_timer #(
  parameter int unsigned TOTAL_CYCLES = 262144,
  parameter int unsigned CNT_W        = $clog2(TOTAL_CYCLES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL_CYCLES - 1);

  logic             busy_d, done_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign cnt_en = busy || start;

  always_comb begin
    busy_d = busy;
    done_d = 1'b0;
    cnt_d  = cnt;
    if (!busy && start) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        cnt_d = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      busy <= busy_d;
      done <= done_d;
      if (cnt_en) cnt <= cnt_d;
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= LAST));
endmodule

// File: rtl/selftest_walk.sv
module selftest_walk #(
  parameter int unsigned NUM_CODES = 128,
  parameter int unsigned NUM_ROWS  = 7,
  parameter int unsigned CODE_W    = 7,
  parameter int unsigned ROW_W     = 3,
  parameter int unsigned DOT_W     = 5,
  parameter int unsigned SUM_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              walk_en,
  output logic [CODE_W-1:0] code,
  output logic [ROW_W-1:0]  row,
  input  logic [DOT_W-1:0]  dots,
  output logic [SUM_W-1:0]  sum
);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(NUM_ROWS - 1);
  localparam logic [CODE_W-1:0] CODE_LAST = CODE_W'(NUM_CODES - 1);

  logic [CODE_W-1:0] code_d;
  logic [ROW_W-1:0]  row_d;
  logic [SUM_W-1:0]  sum_d;
  logic              reg_en;

  assign reg_en = clear || walk_en;

  always_comb begin
    code_d = code;
    row_d  = row;
    sum_d  = sum;
    if (clear) begin
      code_d = '0;
      row_d  = '0;
      sum_d  = '0;
    end else if (walk_en) begin
      sum_d = sum + SUM_W'(dots);
      if (row == ROW_LAST) begin
        row_d = '0;
        if (code != CODE_LAST) code_d = code + 1'b1;
      end else begin
        row_d = row + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code <= '0;
      row  <= '0;
      sum  <= '0;
    end else if (reg_en) begin
      code <= code_d;
      row  <= row_d;
      sum  <= sum_d;
    end
  end

  // R4
  row_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row <= ROW_LAST);
  // R4
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_en && !clear && row != ROW_LAST) |=> (row == $past(row) + 1'b1) && $stable(code));
endmodule

// File: rtl/selftest_pattern.sv
module selftest_pattern #(
  parameter int unsigned TOTAL_CYCLES = 262144,
  parameter int unsigned WALK_CYCLES  = 896,
  parameter int unsigned CNT_W        = $clog2(TOTAL_CYCLES)
) (
  input  logic                      busy,
  input  logic [CNT_W-1:0]          cnt,
  output selftest_pkg::st_phase_e   phase
);
  import selftest_pkg::*;
  localparam int unsigned     HALF  = (TOTAL_CYCLES - WALK_CYCLES) / 2;
  localparam logic [CNT_W-1:0] B_CHK = CNT_W'(WALK_CYCLES);
  localparam logic [CNT_W-1:0] B_INV = CNT_W'(WALK_CYCLES + HALF);

  always_comb begin
    if (!busy)              phase = PH_IDLE;
    else if (cnt < B_CHK)   phase = PH_WALK;
    else if (cnt < B_INV)   phase = PH_CHECK;
    else                    phase = PH_INV;
  end
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq #(
  parameter int unsigned TOTAL_CYCLES = 262144,
  parameter int unsigned NUM_CODES    = 128,
  parameter int unsigned NUM_ROWS     = 7,
  parameter int unsigned DOT_W        = 5,
  parameter logic [7:0]  EXPECTED_SUM = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cw_wr,
  input  logic [7:0] cw_wdata,
  output logic [6:0] font_code,
  output logic [2:0] font_row,
  input  logic [4:0] font_data,
  output logic       busy,
  output logic       pat_en,
  output logic       pat_inv,
  output logic       done,
  output logic       pass_bit
);
  import selftest_pkg::*;
  localparam int unsigned WALK_CYCLES = NUM_CODES * NUM_ROWS;
  localparam int unsigned CNT_W       = $clog2(TOTAL_CYCLES);

  logic             rst_meta, rst_sync_n;
  logic             start, timer_done;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sum;
  st_phase_e        phase;
  logic             pass_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign start = cw_wr && cw_wdata[CW_START_BIT] && !busy;

  selftest_timer #(.TOTAL_CYCLES(TOTAL_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_sync_n), .start(start),
    .busy(busy), .done(timer_done), .cnt(cnt)
  );

  selftest_walk #(
    .NUM_CODES(NUM_CODES), .NUM_ROWS(NUM_ROWS), .CODE_W(7), .ROW_W(3),
    .DOT_W(DOT_W), .SUM_W(8)
  ) u_walk (
    .clk(clk), .rst_n(rst_sync_n), .clear(start),
    .walk_en(phase == PH_WALK), .code(font_code), .row(font_row),
    .dots(font_data), .sum(sum)
  );

  selftest_pattern #(
    .TOTAL_CYCLES(TOTAL_CYCLES), .WALK_CYCLES(WALK_CYCLES), .CNT_W(CNT_W)
  ) u_pat (
    .busy(busy), .cnt(cnt), .phase(phase)
  );

  assign pat_en  = (phase == PH_CHECK) || (phase == PH_INV);
  assign pat_inv = (phase == PH_INV);
  assign done    = timer_done;

  always_comb begin
    pass_d = pass_bit;
    if (busy && cnt == CNT_W'(TOTAL_CYCLES - 1)) pass_d = (sum == EXPECTED_SUM);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) pass_bit <= 1'b0;
    else             pass_bit <= pass_d;
  end

  // R8
  pass_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done |-> $stable(pass_bit));
  // R6
  pattern_busy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pat_en |-> busy);
  // R6
  inv_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pat_inv |-> pat_en);
  // R3
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (busy && cnt != CNT_W'(TOTAL_CYCLES - 1)) |=> busy && (cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/selftest_seq_tb.sv
module selftest_seq_tb;
  localparam int unsigned TOTAL = 2048;
  localparam int unsigned WALK  = 896;
  localparam int unsigned HALF  = (TOTAL - WALK) / 2;

  function automatic logic [4:0] fmodel(input int unsigned c, input int unsigned r);
    return 5'((c * 7 + r * 13 + (c >> 2) + 3) & 31);
  endfunction

  function automatic logic [7:0] good_sum();
    logic [7:0] s = 8'h00;
    for (int c = 0; c < 128; c++)
      for (int r = 0; r < 7; r++) s = s + 8'(fmodel(c, r));
    return s;
  endfunction

  localparam logic [7:0] EXP = good_sum();

  logic clk = 1'b0, rst_n = 1'b0;
  logic cw_wr = 1'b0;
  logic [7:0] cw_wdata = 8'h00;
  logic [6:0] font_code;
  logic [2:0] font_row;
  logic [4:0] font_data;
  logic busy, pat_en, pat_inv, done, pass_bit;
  logic inject = 1'b0;
  logic [6:0] bad_code = 7'd0;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign font_data = fmodel(font_code, font_row) ^
                     ((inject && font_code == bad_code && font_row == 3'd2) ? 5'h04 : 5'h00);

  selftest_seq #(.TOTAL_CYCLES(TOTAL), .EXPECTED_SUM(EXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .cw_wr(cw_wr), .cw_wdata(cw_wdata),
    .font_code(font_code), .font_row(font_row), .font_data(font_data),
    .busy(busy), .pat_en(pat_en), .pat_inv(pat_inv), .done(done), .pass_bit(pass_bit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cw(input logic [7:0] d);
    @(negedge clk); cw_wr = 1'b1; cw_wdata = d;
    @(negedge clk); cw_wr = 1'b0; cw_wdata = 8'h00;
  endtask

  // Starts a run and follows it cycle by cycle; returns busy length.
  task automatic run_test(input logic [7:0] d, input int stray_at, output int blen);
    int k = 0;
    int bad_w = 0, bad_p = 0, bad_d = 0;
    write_cw(d);
    while (busy && k < TOTAL + 10) begin
      if (k < int'(WALK) && (font_code !== 7'(k / 7) || font_row !== 3'(k % 7))) bad_w++;
      if (k < int'(WALK) && pat_en !== 1'b0) bad_p++;
      if (k >= int'(WALK) && k < int'(WALK + HALF) && (pat_en !== 1'b1 || pat_inv !== 1'b0)) bad_p++;
      if (k >= int'(WALK + HALF) && (pat_en !== 1'b1 || pat_inv !== 1'b1)) bad_p++;
      if (done !== 1'b0) bad_d++;
      if (k == stray_at) begin
        cw_wr = 1'b1; cw_wdata = 8'($urandom) | 8'h40;
      end else begin
        cw_wr = 1'b0; cw_wdata = 8'h00;
      end
      k++;
      @(negedge clk);
    end
    cw_wr = 1'b0;
    blen = k;
    chk("R4 walk code/row", bad_w, 0);
    chk("R6 pattern phases", bad_p, 0);
    chk("R7 no done while busy", bad_d, 0);
    chk("R7 done after run", {busy, done}, 2'b01);
    chk("R6 pattern off after run", pat_en, 1'b0);
    @(negedge clk);
    chk("R7 done single cycle", done, 1'b0);
  endtask

  initial begin
    int blen;
    logic [31:0] seed_dummy;
    seed_dummy = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 1'b0);
    chk("R1 reset outputs", {done, pass_bit, pat_en, pat_inv}, 4'b0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {busy, done, pass_bit, pat_en}, 4'b0000);

    // R2: write without bit 6 starts nothing
    write_cw(8'hBF);
    chk("R2 no start without bit6", busy, 1'b0);

    // good run with a stray write inside walk
    run_test(8'h40, int'($urandom % WALK), blen);
    chk("R2 busy length", blen, TOTAL);
    chk("R3 stray write no extend", blen, TOTAL);
    chk("R5 pass good font", pass_bit, 1'b1);

    // R8: host writes with bit5 clear do not touch pass_bit
    write_cw(8'h00);
    write_cw(8'h9F);
    chk("R8 pass read-only", pass_bit, 1'b1);

    // corrupted font, stray write in pattern phase
    bad_code = 7'($urandom % 128);
    inject = 1'b1;
    run_test(8'hC0 | 8'($urandom & 8'h3F), int'(WALK + ($urandom % (TOTAL - WALK))), blen);
    inject = 1'b0;
    chk("R3 busy length under stray write", blen, TOTAL);
    chk("R5 fail on bad checksum", pass_bit, 1'b0);

    // corner: bad at last code, stray write at final busy cycle
    bad_code = 7'd127;
    inject = 1'b1;
    run_test(8'h40, TOTAL - 1, blen);
    inject = 1'b0;
    chk("R2 length with late write", blen, TOTAL);
    chk("R5 fail at last code", pass_bit, 1'b0);

    // clean run restores pass
    run_test(8'h7F, int'($urandom % TOTAL), blen);
    chk("R5 pass restored", pass_bit, 1'b1);
    chk("R8 pass stays idle", busy, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule